// File: doc/BRIEF.md
# Bounded Cascadable Up-Counter

This block is a synchronous binary up-counter. Its width is a parameter with a default of 4 bits. It has a synchronous clear, a synchronous parallel load and a count enable. A carry output goes high while the counter is at its top value and is enabled, so several stages can be chained into a wider counter.

An optional bounding stage compares the count with a programmable end value. When the count reaches that value, the stage can send the counter back to a programmable start value, or back to zero, in place of the normal binary wrap. A 2-bit mode input chooses the behaviour. When the parameter `HAS_BOUNDS` is 0, the comparator is left out entirely.

All state changes on the rising clock edge. The reset is synchronous and active low.

Top module: `span_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count becomes 0. The carry output is then 0.
- R2: `clr` high sets the count to 0 at the next edge. It takes priority over `ld`, `en` and the end-value match.
- R3: With `clr` low, `ld` high copies `ld_data` into the count at the next edge. It takes priority over `en` and the end-value match.
- R4: With `clr`, `ld` and `en` all low, the count keeps its value.
- R5: In free mode with `en` high, the count increases by 1 at each edge. From all ones it wraps to 0.
- R6: `carry_out` is 1 exactly when the count is all ones and `en` is 1.
- R7: In start-reload mode (`wrap_mode`=2'b01), with `en` high and the count equal to `end_val`, the next count is `start_val`.
- R8: In zero-return mode (`wrap_mode`=2'b10), with `en` high and the count equal to `end_val`, the next count is 0.
- R9: In free mode (`wrap_mode`=2'b00 or 2'b11), `end_val` and `start_val` have no effect, and the count passes beyond `end_val`.
- R10: Two stages chained, with the low stage's `carry_out` driving the high stage's `en`, count as one 8-bit counter. The high stage advances only on the edge where the low stage goes from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear to zero |
| ld | input | 1 | Synchronous parallel load |
| ld_data | input | WIDTH | Value copied into the count on load |
| en | input | 1 | Count enable |
| start_val | input | WIDTH | Reload value in start-reload mode |
| end_val | input | WIDTH | Bound that triggers a wrap in the bounded modes |
| wrap_mode | input | 2 | 00/11 free, 01 reload start, 10 return to zero |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | All ones and enabled, for cascading |

## Verification
The count can be at `end_val` in the same cycle that a load or a clear is requested. The bench provokes this by parking the counter on the bound and then raising `ld` with a distinct value, and separately by raising `clr` and `ld` together. The load value must win over the wrap target, and zero must win over the load. A second collision is tested by dropping `en` while the count sits at all ones: the carry must fall in that same cycle, and the count must stay put.

// File: rtl/span_cnt_pkg.sv
package span_cnt_pkg;
   typedef enum logic [1:0] {
      WRAP_FREE     = 2'b00,
      WRAP_START    = 2'b01,
      WRAP_ZERO     = 2'b10,
      WRAP_FREE_ALT = 2'b11
   } wrap_mode_e;
endpackage

// File: rtl/span_cnt_incr.sv
module span_cnt_incr #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt,
   output logic             top
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
   assign nxt = cur + ONE;
   assign top = &cur;
endmodule

// File: rtl/span_cnt_wrap.sv
module span_cnt_wrap
   import span_cnt_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter bit HAS_BOUNDS = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] bound,
   input  logic [WIDTH-1:0] restart,
   input  logic [1:0]       mode,
   output logic             hit,
   output logic [WIDTH-1:0] target
);
   generate
      if (HAS_BOUNDS) begin : g_bounds
         logic match;
         logic active;
         assign match  = (cur == bound);
         assign active = (mode == WRAP_START) || (mode == WRAP_ZERO);
         assign hit    = match && active;
         assign target = (mode == WRAP_START) ? restart : '0;
      end else begin : g_free
         assign hit    = 1'b0;
         assign target = '0;
      end
   endgenerate
endmodule

// File: rtl/span_cnt_state.sv
module span_cnt_state #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_data,
   input  logic             en,
   input  logic             wrap_hit,
   input  logic [WIDTH-1:0] wrap_target,
   input  logic [WIDTH-1:0] inc_val,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] d;

   always_comb begin
      d = q;
      if (clr)           d = '0;
      else if (ld)       d = ld_data;
      else if (en) begin
         if (wrap_hit)   d = wrap_target;
         else            d = inc_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/span_counter.sv
module span_counter
   import span_cnt_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter bit HAS_BOUNDS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld,
   input  logic [WIDTH-1:0] ld_data,
   input  logic             en,
   input  logic [WIDTH-1:0] start_val,
   input  logic [WIDTH-1:0] end_val,
   input  logic [1:0]       wrap_mode,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);
   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("span_counter: WIDTH must be 1..64");
      end
   endgenerate

   logic [WIDTH-1:0] inc_val;
   logic             at_top;
   logic             wrap_hit;
   logic [WIDTH-1:0] wrap_target;

   span_cnt_incr #(.WIDTH(WIDTH)) u_incr (
      .cur (count),
      .nxt (inc_val),
      .top (at_top)
   );

   span_cnt_wrap #(.WIDTH(WIDTH), .HAS_BOUNDS(HAS_BOUNDS)) u_wrap (
      .cur     (count),
      .bound   (end_val),
      .restart (start_val),
      .mode    (wrap_mode),
      .hit     (wrap_hit),
      .target  (wrap_target)
   );

   span_cnt_state #(.WIDTH(WIDTH)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .ld          (ld),
      .ld_data     (ld_data),
      .en          (en),
      .wrap_hit    (wrap_hit),
      .wrap_target (wrap_target),
      .inc_val     (inc_val),
      .q           (count)
   );

   assign carry_out = at_top & en;
endmodule

// File: rtl/span_counter_chk.sv
module span_counter_chk
   import span_cnt_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter bit HAS_BOUNDS = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             ld,
   input logic [WIDTH-1:0] ld_data,
   input logic             en,
   input logic [WIDTH-1:0] start_val,
   input logic [WIDTH-1:0] end_val,
   input logic [1:0]       wrap_mode,
   input logic [WIDTH-1:0] count,
   input logic             carry_out
);
   logic free_mode;
   assign free_mode = (wrap_mode == WRAP_FREE) || (wrap_mode == WRAP_FREE_ALT);

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ld) |=> count == $past(ld_data));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && !en) |=> $stable(count));

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && en && free_mode) |=> count == WIDTH'($past(count) + 1'b1));

   p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> (en && count == {WIDTH{1'b1}}));

   p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_BOUNDS && !clr && !ld && en && wrap_mode == WRAP_START && count == end_val)
      |=> count == $past(start_val));

   p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_BOUNDS && !clr && !ld && en && wrap_mode == WRAP_ZERO && count == end_val)
      |=> count == '0);
endmodule

bind span_counter span_counter_chk #(.WIDTH(WIDTH), .HAS_BOUNDS(HAS_BOUNDS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .ld        (ld),
   .ld_data   (ld_data),
   .en        (en),
   .start_val (start_val),
   .end_val   (end_val),
   .wrap_mode (wrap_mode),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/span_counter_test.sv
`timescale 1ns/1ps
module span_counter_test;
   logic       clk = 1'b0;
   logic       rst_n, clr, ld, en;
   logic [3:0] ld_data, start_val, end_val;
   logic [1:0] wrap_mode;
   logic [3:0] count;
   logic       carry_out;

   logic       c_rst_n, c_en;
   logic [3:0] lo_q, hi_q;
   logic       lo_co, hi_co;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   span_counter uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_data(ld_data), .en(en),
      .start_val(start_val), .end_val(end_val), .wrap_mode(wrap_mode),
      .count(count), .carry_out(carry_out)
   );

   span_counter u_lo (
      .clk(clk), .rst_n(c_rst_n), .clr(1'b0), .ld(1'b0), .ld_data(4'h0), .en(c_en),
      .start_val(4'h0), .end_val(4'h0), .wrap_mode(2'b00),
      .count(lo_q), .carry_out(lo_co)
   );

   span_counter u_hi (
      .clk(clk), .rst_n(c_rst_n), .clr(1'b0), .ld(1'b0), .ld_data(4'h0), .en(lo_co),
      .start_val(4'h0), .end_val(4'h0), .wrap_mode(2'b00),
      .count(hi_q), .carry_out(hi_co)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      clr = 0; ld = 0; en = 0;
   endtask

   task automatic preset(input logic [3:0] v);
      idle(); ld = 1; ld_data = v; tick(); ld = 0;
   endtask

   task automatic t_reset();
      rst_n = 0; idle(); en = 1; ld_data = 4'h0; start_val = 0; end_val = 0; wrap_mode = 2'b00;
      tick(); tick();
      check("R1 count", {4'h0, count}, 8'h0);
      en = 0; #0.5;
      check("R1 carry", {7'h0, carry_out}, 8'h0);
      rst_n = 1;
   endtask

   task automatic t_free();
      idle(); wrap_mode = 2'b00; en = 1;
      for (int i = 0; i < 5; i++) tick();
      check("R5 five steps", {4'h0, count}, 8'h05);
      for (int i = 0; i < 10; i++) tick();
      check("R5 reach top", {4'h0, count}, 8'h0F);
      check("R6 carry high", {7'h0, carry_out}, 8'h1);
      en = 0; #0.5;
      check("R6 carry needs en", {7'h0, carry_out}, 8'h0);
      tick();
      check("R4 hold", {4'h0, count}, 8'h0F);
      en = 1; tick();
      check("R5 wrap to zero", {4'h0, count}, 8'h00);
      check("R6 carry low off top", {7'h0, carry_out}, 8'h0);
   endtask

   task automatic t_load_clear();
      idle(); en = 1; ld = 1; ld_data = 4'h9; tick();
      check("R3 load beats enable", {4'h0, count}, 8'h09);
      clr = 1; ld = 1; ld_data = 4'h5; tick();
      check("R2 clear beats load", {4'h0, count}, 8'h00);
      idle();
   endtask

   task automatic t_reload();
      wrap_mode = 2'b01; start_val = 4'h6; end_val = 4'hD;
      preset(4'hC); en = 1;
      tick();
      check("R7 reach bound", {4'h0, count}, 8'h0D);
      tick();
      check("R7 reload start", {4'h0, count}, 8'h06);
      tick();
      check("R7 step after reload", {4'h0, count}, 8'h07);
      preset(4'hD); en = 1; ld = 1; ld_data = 4'h2; tick();
      check("R3 load beats bound", {4'h0, count}, 8'h02);
      idle(); preset(4'hD); clr = 1; en = 1; tick();
      check("R2 clear beats bound", {4'h0, count}, 8'h00);
      idle();
   endtask

   task automatic t_zero();
      wrap_mode = 2'b10; start_val = 4'h6; end_val = 4'hD;
      preset(4'hC); en = 1;
      tick(); tick();
      check("R8 return to zero", {4'h0, count}, 8'h00);
      tick();
      check("R8 step after zero", {4'h0, count}, 8'h01);
      idle(); preset(4'hD); tick();
      check("R4 hold on bound", {4'h0, count}, 8'h0D);
   endtask

   task automatic t_free_ignores();
      wrap_mode = 2'b00; end_val = 4'hD; start_val = 4'h6;
      preset(4'hD); en = 1; tick();
      check("R9 mode 00 passes bound", {4'h0, count}, 8'h0E);
      wrap_mode = 2'b11; end_val = 4'hE; tick();
      check("R9 mode 11 passes bound", {4'h0, count}, 8'h0F);
      idle();
   endtask

   task automatic t_cascade();
      logic [7:0] exp;
      c_rst_n = 0; c_en = 0; tick(); c_rst_n = 1;
      check("R10 reset", {hi_q, lo_q}, 8'h00);
      exp = 8'h00; c_en = 1;
      for (int i = 0; i < 258; i++) begin
         tick();
         exp = exp + 8'h01;
         check("R10 chained value", {hi_q, lo_q}, exp);
      end
      c_en = 0; tick();
      check("R10 chained hold", {hi_q, lo_q}, exp);
   endtask

   initial begin
      c_rst_n = 0; c_en = 0;
      t_reset();
      t_free();
      t_load_clear();
      t_reload();
      t_zero();
      t_free_ignores();
      t_cascade();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule